// File: doc/BRIEF.md
# Write-Masked Side-Band Control Register Bank

This block holds six 16-bit control registers and one read-only status word behind a simple register-write bus, and drives a link PHY's side-band pins straight from the stored bits. Each 32-bit write carries its own per-bit enable mask in the upper half. A write therefore changes only the bits it names, so one field can be updated without first reading the register back. Software moves a multi-bit field of width `w` at shift `s` by setting mask bits `(2^w - 1) << (s + 16)`.

Two of the registers feed decoded outputs. One carries the per-lane enable, force-receive, force-stop and turnaround-disable nibbles. The other carries an 8-bit test code bus together with its enable, clock and clear strobes. A write to address zero is taken as a programming error and raises a flag for one cycle. Reads are registered: the word appears on the cycle after the read request.

Top module: `sbctl_bank`

## Requirements
- R1: On a write to a mapped control offset, stored bit i (0 to 15) takes `wr_data[i]` when `wr_data[i+16]` is 1. The new value is visible on the outputs from the cycle after the write edge.
- R2: On a mapped write, every stored bit whose enable bit `wr_data[i+16]` is 0 keeps its previous value. A register that is not addressed does not change.
- R3: While `rst` is high, all six control registers, `rd_data` and `err_zero_wr` are zero. They stay zero after reset until they are written or read.
- R4: Control register slots 0 to 5 sit at byte offsets 0x6224, 0x6254, 0x6258, 0x625C, 0x6260 and 0x6264, and slot k drives `ctl_flat[16k+15:16k]`. A read returns the stored 16 bits in `rd_data[15:0]` with `rd_data[31:16]` zero, in the cycle after `rd_en`. A read in the same cycle as a write to the same register returns the value from before the write.
- R5: Slot 1 (0x6254) drives `lane_en` from bits [3:0], `force_rx` from [7:4], `force_stop` from [11:8] and `turn_dis` from [15:12].
- R6: Slot 5 (0x6264) drives `test_din` from bits [7:0], `test_en` from bit 8, `test_clk` from bit 9 and `test_clr` from bit 10.
- R7: A read of 0xE2A4 returns `test_dout`, sampled at the read edge, in bits [7:0], with all other bits zero. Writes to 0xE2A4 change no register.
- R8: A write to offset 0 sets `err_zero_wr` high for exactly the following cycle and changes no register. `err_zero_wr` is low in every other cycle.
- R9: Writes to unmapped offsets change no register. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 16 | Write byte offset |
| wr_data | input | 32 | Data in [15:0], per-bit enables in [31:16] |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 32 | Registered read word |
| err_zero_wr | output | 1 | One-cycle flag after a write to offset 0 |
| test_dout | input | 8 | Test code read-back from the PHY |
| ctl_flat | output | 96 | All six control registers, slot 0 in the low bits |
| lane_en | output | 4 | Per-lane enable |
| force_rx | output | 4 | Per-lane force-receive mode |
| force_stop | output | 4 | Per-lane force-stop state |
| turn_dis | output | 4 | Per-lane turnaround disable |
| test_din | output | 8 | Test code/data bus |
| test_en | output | 1 | Test enable strobe |
| test_clk | output | 1 | Test clock line |
| test_clr | output | 1 | Test clear line |

## Verification
A read and a write can arrive in the same cycle and address the same register. The bench forces this by raising both requests on one edge for slot 2. The scoreboard expects the pre-write word on `rd_data`, and a second read must then return the masked-in value. A write to offset zero is also checked in the same way: the flag must rise for one cycle while the whole `ctl_flat` bus stays unchanged.

// File: rtl/sbctl_pkg.sv
package sbctl_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int N_CTL    = 6;
  localparam int ADDR_W   = 16;
  localparam int LANES    = 4;
  localparam int TCODE_W  = 8;

  // slots with decoded side-band fields
  localparam int LANE_SLOT = 1;
  localparam int TEST_SLOT = 5;

  // field shifts within the lane register
  localparam int SH_LANE_EN = 0;
  localparam int SH_FRX     = 4;
  localparam int SH_FSTOP   = 8;
  localparam int SH_TDIS    = 12;

  // field shifts within the test register
  localparam int SH_TDIN = 0;
  localparam int SH_TEN  = 8;
  localparam int SH_TCLK = 9;
  localparam int SH_TCLR = 10;

  localparam logic [ADDR_W-1:0] STATUS_OFF = 16'hE2A4;

  function automatic logic [ADDR_W-1:0] ctl_off(input int k);
    case (k)
      0:       ctl_off = 16'h6224;
      1:       ctl_off = 16'h6254;
      2:       ctl_off = 16'h6258;
      3:       ctl_off = 16'h625C;
      4:       ctl_off = 16'h6260;
      default: ctl_off = 16'h6264;
    endcase
  endfunction
endpackage

// File: rtl/sbctl_decode.sv
module sbctl_decode
  import sbctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int N  = N_CTL
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit,
  output logic          hit_status,
  output logic          hit_zero
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit[k] = en && (addr == AW'(ctl_off(k)));
  end
  assign hit_status = en && (addr == AW'(STATUS_OFF));
  assign hit_zero   = en && (addr == '0);
endmodule

// File: rtl/sbctl_mreg.sv
module sbctl_mreg
  import sbctl_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0] q
);
  logic [HW-1:0] mask, dat;
  assign mask = wdata[2*HW-1:HW];
  assign dat  = wdata[HW-1:0];

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (sel) q <= (q & ~mask) | (dat & mask);
  end

  a_r1_enabled_bits_take: assert property (@(posedge clk) disable iff (rst)
    sel |=> ((q & $past(mask)) == ($past(dat) & $past(mask))));
  a_r2_disabled_bits_keep: assert property (@(posedge clk) disable iff (rst)
    sel |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
  a_r2_unselected_keep: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(q));
endmodule

// File: rtl/sbctl_rdmux.sv
module sbctl_rdmux
  import sbctl_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int N  = N_CTL,
  parameter int SW = TCODE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [N-1:0]    hit,
  input  logic            hit_status,
  input  logic [N*HW-1:0] regs,
  input  logic [SW-1:0]   status,
  output logic [2*HW-1:0] rd_data
);
  logic [HW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < N; k++)
      if (hit[k]) sel_word = regs[k*HW +: HW];
    if (hit_status) sel_word = HW'(status);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{HW{1'b0}}, sel_word};
  end

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit == '0 && !hit_status) |=> (rd_data == '0));
  a_r4_upper_half_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[2*HW-1:HW] == '0));
endmodule

// File: rtl/sbctl_bank.sv
module sbctl_bank
  import sbctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HALF_W,
  parameter int N  = N_CTL,
  parameter int NL = LANES,
  parameter int TW = TCODE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*HW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*HW-1:0] rd_data,
  output logic            err_zero_wr,
  input  logic [TW-1:0]   test_dout,
  output logic [N*HW-1:0] ctl_flat,
  output logic [NL-1:0]   lane_en,
  output logic [NL-1:0]   force_rx,
  output logic [NL-1:0]   force_stop,
  output logic [NL-1:0]   turn_dis,
  output logic [TW-1:0]   test_din,
  output logic            test_en,
  output logic            test_clk,
  output logic            test_clr
);
  logic [N-1:0] wr_hit, rd_hit;
  logic         wr_status, wr_zero, rd_status, rd_zero;
  logic [HW-1:0] lane_w, test_w;

  sbctl_decode #(.AW(AW), .N(N)) u_wdec (
    .en(wr_en), .addr(wr_addr), .hit(wr_hit),
    .hit_status(wr_status), .hit_zero(wr_zero));

  sbctl_decode #(.AW(AW), .N(N)) u_rdec (
    .en(rd_en), .addr(rd_addr), .hit(rd_hit),
    .hit_status(rd_status), .hit_zero(rd_zero));

  for (genvar k = 0; k < N; k++) begin : g_reg
    sbctl_mreg #(.HW(HW)) u_reg (
      .clk(clk), .rst(rst), .sel(wr_hit[k]),
      .wdata(wr_data), .q(ctl_flat[k*HW +: HW]));
  end

  sbctl_rdmux #(.HW(HW), .N(N), .SW(TW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .hit(rd_hit),
    .hit_status(rd_status), .regs(ctl_flat), .status(test_dout),
    .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (rst) err_zero_wr <= 1'b0;
    else     err_zero_wr <= wr_zero;
  end

  assign lane_w     = ctl_flat[LANE_SLOT*HW +: HW];
  assign test_w     = ctl_flat[TEST_SLOT*HW +: HW];
  assign lane_en    = lane_w[SH_LANE_EN +: NL];
  assign force_rx   = lane_w[SH_FRX +: NL];
  assign force_stop = lane_w[SH_FSTOP +: NL];
  assign turn_dis   = lane_w[SH_TDIS +: NL];
  assign test_din   = test_w[SH_TDIN +: TW];
  assign test_en    = test_w[SH_TEN];
  assign test_clk   = test_w[SH_TCLK];
  assign test_clr   = test_w[SH_TCLR];

  a_r8_zero_write_flags: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> err_zero_wr);
  a_r8_flag_only_after_zero: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == '0) |=> !err_zero_wr);
  a_r8_zero_write_no_change: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> $stable(ctl_flat));
  a_r7_status_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(STATUS_OFF)) |=> (rd_data[TW-1:0] == $past(test_dout)));
  a_r7_status_write_no_change: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(STATUS_OFF)) |=> $stable(ctl_flat));
endmodule

// File: tb/sbctl_bank_tb_top.sv
module sbctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_zero_wr;
  logic [7:0]  test_dout = '0;
  logic [95:0] ctl_flat;
  logic [3:0]  lane_en, force_rx, force_stop, turn_dis;
  logic [7:0]  test_din;
  logic        test_en, test_clk, test_clr;

  int total = 0, bad = 0;
  logic [15:0] m [6];
  logic [15:0] offs [6] = '{16'h6224, 16'h6254, 16'h6258, 16'h625C, 16'h6260, 16'h6264};
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  sbctl_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .err_zero_wr(err_zero_wr),
    .test_dout(test_dout), .ctl_flat(ctl_flat), .lane_en(lane_en),
    .force_rx(force_rx), .force_stop(force_stop), .turn_dis(turn_dis),
    .test_din(test_din), .test_en(test_en), .test_clk(test_clk), .test_clr(test_clr));

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] model_flat();
    logic [95:0] f;
    for (int k = 0; k < 6; k++) f[k*16 +: 16] = m[k];
    return f;
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] d);
    for (int k = 0; k < 6; k++)
      if (a == offs[k]) m[k] = (m[k] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < 6; k++) if (a == offs[k]) r = {16'h0, m[k]};
    if (a == 16'hE2A4) r = {24'h0, test_dout};
    return r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    chk("R8 flag after write", {95'h0, err_zero_wr}, {95'h0, (a == 16'h0)});
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    @(posedge clk); #2;
    chk("R8 flag one cycle", {95'h0, err_zero_wr}, 96'h0);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(model_read(a)); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops the expected word for every read the DUT sampled
  always @(posedge clk) begin
    if (!rst && rd_en) begin
      #2;
      if (exp_q.size() == 0) chk("scoreboard underflow", 96'h1, 96'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {64'h0, rd_data}, {64'h0, e});
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk("watchdog expired", 96'h1, 96'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) m[k] = '0;
    repeat (4) @(posedge clk);
    #2;
    chk("R3 reset ctl", ctl_flat, 96'h0);
    chk("R3 reset rd_data", {64'h0, rd_data}, 96'h0);
    chk("R3 reset err", {95'h0, err_zero_wr}, 96'h0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 6; k++) rd(offs[k], "R3 read after reset");

    // R5 lane fields, one at a time
    wr(16'h6254, 32'h000F_0005);
    chk("R5 lane_en", {92'h0, lane_en}, 96'h5);
    wr(16'h6254, 32'h00F0_00A0);
    chk("R5 force_rx", {92'h0, force_rx}, 96'hA);
    chk("R2 lane_en kept", {92'h0, lane_en}, 96'h5);
    wr(16'h6254, 32'hFF00_F3FF);
    chk("R5 force_stop", {92'h0, force_stop}, 96'h3);
    chk("R5 turn_dis", {92'h0, turn_dis}, 96'hF);
    chk("R2 force_rx kept", {92'h0, force_rx}, 96'hA);
    rd(16'h6254, "R4 lane register read");

    // R6 test interface lines
    wr(16'h6264, 32'h00FF_005A);
    chk("R6 test_din", {88'h0, test_din}, 96'h5A);
    wr(16'h6264, 32'h0100_0100);
    chk("R6 test_en", {95'h0, test_en}, 96'h1);
    wr(16'h6264, 32'h0200_0200);
    chk("R6 test_clk", {95'h0, test_clk}, 96'h1);
    wr(16'h6264, 32'h0400_0400);
    chk("R6 test_clr", {95'h0, test_clr}, 96'h1);
    wr(16'h6264, 32'h0300_0000);
    chk("R6 clk/en cleared", {94'h0, test_clk, test_en}, 96'h0);
    chk("R6 clr kept", {95'h0, test_clr}, 96'h1);

    // R1/R2 full and partial masks on the other slots
    wr(16'h6224, 32'hFFFF_1234);
    wr(16'h6258, 32'hFFFF_BEEF);
    wr(16'h625C, 32'hFFFF_0F0F);
    wr(16'h6260, 32'hFFFF_8001);
    chk("R1 full mask writes", ctl_flat, model_flat());
    wr(16'h6224, 32'h0F0F_FFFF);
    rd(16'h6224, "R1 partial mask read");
    chk("R2 partial mask", {80'h0, ctl_flat[15:0]}, 96'h1F3F);
    wr(16'h6260, 32'h0000_FFFF);
    chk("R2 zero mask", ctl_flat, model_flat());
    for (int k = 0; k < 6; k++) rd(offs[k], "R4 readback");

    // R7 status
    test_dout = 8'hC3;
    rd(16'hE2A4, "R7 status read");
    test_dout = 8'h3C;
    rd(16'hE2A4, "R7 status second value");
    wr(16'hE2A4, 32'hFFFF_FFFF);
    chk("R7 status write ignored", ctl_flat, model_flat());

    // R8 zero-offset write
    wr(16'h0000, 32'hFFFF_FFFF);
    chk("R8 zero write no change", ctl_flat, model_flat());

    // R9 unmapped offsets
    wr(16'h6228, 32'hFFFF_FFFF);
    wr(16'h6250, 32'hFFFF_0000);
    chk("R9 unmapped write ignored", ctl_flat, model_flat());
    rd(16'h1234, "R9 unmapped read");
    rd(16'h6228, "R9 unmapped read near map");

    // R4 same-cycle read and write to one register
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h6258; wr_data = 32'hFF00_5500;
    rd_en = 1'b1; rd_addr = 16'h6258;
    exp_q.push_back({16'h0, m[2]}); tag_q.push_back("R4 collision old value");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(16'h6258, 32'hFF00_5500);
    rd(16'h6258, "R4 after collision");

    // R3 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk("R3 second reset", ctl_flat, 96'h0);
    chk("R3 second reset rd_data", {64'h0, rd_data}, 96'h0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 6; k++) m[k] = '0;
    rd(16'h6254, "R3 read after second reset");

    repeat (4) @(posedge clk);
    #2;
    chk("scoreboard drained", {64'h0, 32'(exp_q.size())}, 96'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule